// File: doc/BRIEF.md
# FIFO Flag Test Sequencer

This block runs a self-test on a synchronous FIFO that sits beside it. Each pass starts from an empty FIFO. The block writes one word per location until its own occupancy count reaches the FIFO depth, then reads one word at a time until the count is back at zero. After every write and every read it spends one cycle checking the FIFO's full, empty, almost-full and almost-empty flags against that count. It also checks each word read back against the word that was written into the same position.

The almost thresholds are driven to the FIFO by the block. The first pass uses a threshold whose odd bits are ones and whose even bits are zeros. The second pass uses the complement of that pattern. Write data is the per-pass write index XORed with an alternating pattern that also flips between the passes, so a stuck or swapped data line shows up as a data mismatch.

A mode input selects the FIFO's read timing:
- In standard timing, a word appears on the read data bus one cycle after the read strobe.
- In fall-through timing, the head word is already on the bus before it is popped.

Any mismatch latches an error. The occupancy at which the first mismatch was seen is kept for diagnosis, and the sequence still runs to completion.

Top module: `fifo_flag_bist`

## Requirements
- R1: While reset is held, done, error, the write strobe and the read strobe are all 0, and the occupancy record and threshold output are 0.
- R2: start is acted on only when the block is idle or has finished. A start pulse during a running sequence has no effect on the strobes, the run length or the result.
- R3: During the first pass the threshold output equals the THR_W-bit word with ones in its odd bit positions (0xAAAA truncated). During the second pass it equals the word with ones in its even bit positions (0x5555 truncated). It holds steady within a pass.
- R4: Each pass issues exactly DEPTH writes followed by exactly DEPTH reads. No write is issued when the FIFO already holds DEPTH words. Write and read strobes are single-cycle pulses that are never active together, and each is followed by a check cycle with no strobe.
- R5: The k-th write of a pass (k from 0) carries k modulo 2^WIDTH XOR a WIDTH-bit pattern. In the first pass the pattern has ones in its odd bit positions; in the second pass it has ones in its even bit positions.
- R6: Before the first write of each pass, and after every write and every read, full is checked to be 1 exactly when occupancy equals DEPTH, and empty to be 1 exactly when occupancy is 0.
- R7: At the same checks, almost-full must be 1 exactly when occupancy plus threshold is at least DEPTH, and almost-empty must be 1 exactly when occupancy is at most the threshold.
- R8: In standard timing (fwftMode=0), read data is compared in the cycle after the read strobe, against the word written at the same position of the pass.
- R9: In fall-through timing (fwftMode=1), read data is compared in the cycle of the read strobe, before the pop.
- R10: Any flag or data mismatch sets error, which stays set until the next accepted start. errOcc keeps the occupancy at the first mismatch. For a data check in fall-through timing, that is the occupancy before the pop; for every other check, it is the occupancy after the preceding strobe.
- R11: done rises 8*DEPTH+2 clock edges after the edge that accepts start. It then holds with no strobes until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a two-pass sequence |
| fwftMode | input | 1 | 1 = fall-through read timing, 0 = standard |
| fifoWrEn | output | 1 | Write strobe to the FIFO |
| fifoWrData | output | WIDTH | Write data to the FIFO |
| fifoRdEn | output | 1 | Read strobe to the FIFO |
| fifoRdData | input | WIDTH | Read data from the FIFO |
| fifoFull | input | 1 | FIFO full flag |
| fifoEmpty | input | 1 | FIFO empty flag |
| fifoAlmostFull | input | 1 | FIFO almost-full flag |
| fifoAlmostEmpty | input | 1 | FIFO almost-empty flag |
| almostThresh | output | THR_W | Threshold driven to both almost flags |
| done | output | 1 | Sequence finished |
| error | output | 1 | Sticky mismatch indication |
| errOcc | output | CNT_W | Occupancy at the first mismatch |

## Verification
The assertions check on every cycle:
- the strobe discipline: strobes never overlap and are never back-to-back;
- that error and its recorded occupancy are sticky;
- that done holds and stays quiet;
- that the threshold is steady while writes are issued.

Only the bench scenarios can show the rest. These are the write data order, the per-pass threshold values, the exact run length, the two read timings, and that injected faults on each flag and on a stored word are caught at the right occupancy. The bench does this with a behavioural FIFO whose flags or contents it corrupts on purpose.

// File: rtl/fifoflag_pkg.sv
package fifoflag_pkg;

  typedef struct packed {
    logic clear;
    logic nextPass;
    logic doWrite;
    logic doRead;
    logic chkFlags;
    logic chkData;
  } seqStrobe_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ARM,
    ST_WRITE,
    ST_FILLCHK,
    ST_READ,
    ST_DRAINCHK,
    ST_DONE
  } seqState_t;

endpackage

// File: rtl/ffseq_ctrl.sv
module ffseq_ctrl
  import fifoflag_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       fwftMode,
  input  logic       isFull,
  input  logic       isEmpty,
  input  logic       lastPass,
  output seqStrobe_t strb,
  output logic       done
);

  seqState_t state, nxtState;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nxtState;
  end

  always_comb begin
    nxtState = state;
    strb     = '0;
    case (state)
      ST_IDLE, ST_DONE: begin
        if (start) begin
          strb.clear = 1'b1;
          nxtState   = ST_ARM;
        end
      end
      ST_ARM: begin
        strb.chkFlags = 1'b1;
        nxtState      = ST_WRITE;
      end
      ST_WRITE: begin
        strb.doWrite = 1'b1;
        nxtState     = ST_FILLCHK;
      end
      ST_FILLCHK: begin
        strb.chkFlags = 1'b1;
        nxtState      = isFull ? ST_READ : ST_WRITE;
      end
      ST_READ: begin
        strb.doRead  = 1'b1;
        strb.chkData = fwftMode;
        nxtState     = ST_DRAINCHK;
      end
      ST_DRAINCHK: begin
        strb.chkFlags = 1'b1;
        strb.chkData  = !fwftMode;
        if (!isEmpty) begin
          nxtState = ST_READ;
        end else if (lastPass) begin
          nxtState = ST_DONE;
        end else begin
          strb.nextPass = 1'b1;
          nxtState      = ST_ARM;
        end
      end
      default: nxtState = ST_IDLE;
    endcase
  end

  assign done = (state == ST_DONE);

endmodule

// File: rtl/ffseq_datapath.sv
module ffseq_datapath
  import fifoflag_pkg::*;
#(
  parameter  int DEPTH = 8192,
  parameter  int WIDTH = 4,
  parameter  int THR_W = 13,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  seqStrobe_t       strb,
  input  logic [WIDTH-1:0] rdData,
  input  logic             fullIn,
  input  logic             emptyIn,
  input  logic             almostFullIn,
  input  logic             almostEmptyIn,
  output logic [WIDTH-1:0] wrData,
  output logic [THR_W-1:0] thrOut,
  output logic             isFull,
  output logic             isEmpty,
  output logic             lastPass,
  output logic             errFlag,
  output logic [CNT_W-1:0] errOccOut
);

  function automatic logic [WIDTH-1:0] dataPat(input logic oddOnes);
    logic [WIDTH-1:0] w;
    for (int i = 0; i < WIDTH; i++) w[i] = ((i % 2) == 1) ? oddOnes : !oddOnes;
    return w;
  endfunction

  function automatic logic [THR_W-1:0] thrPat(input logic oddOnes);
    logic [THR_W-1:0] w;
    for (int i = 0; i < THR_W; i++) w[i] = ((i % 2) == 1) ? oddOnes : !oddOnes;
    return w;
  endfunction

  localparam logic [WIDTH-1:0] DATA_A = dataPat(1'b1);
  localparam logic [WIDTH-1:0] DATA_B = dataPat(1'b0);
  localparam logic [THR_W-1:0] THR_A  = thrPat(1'b1);
  localparam logic [THR_W-1:0] THR_B  = thrPat(1'b0);

  logic [CNT_W-1:0] occ, wrIdx, rdIdx;
  logic             passB;
  logic [THR_W-1:0] thr;
  logic [WIDTH-1:0] curPat, expData;
  logic [3:0]       flagsSeen, flagsExp;
  logic             mismatch;

  assign curPat  = passB ? DATA_B : DATA_A;
  assign wrData  = WIDTH'(wrIdx) ^ curPat;
  assign expData = WIDTH'(rdIdx) ^ curPat;

  assign flagsSeen = {fullIn, emptyIn, almostFullIn, almostEmptyIn};
  assign flagsExp  = {occ == CNT_W'(DEPTH),
                      occ == '0,
                      (32'(occ) + 32'(thr)) >= 32'(DEPTH),
                      32'(occ) <= 32'(thr)};

  assign mismatch = (strb.chkFlags && (flagsSeen != flagsExp)) ||
                    (strb.chkData  && (rdData != expData));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      occ       <= '0;
      wrIdx     <= '0;
      rdIdx     <= '0;
      passB     <= 1'b0;
      thr       <= '0;
      errFlag   <= 1'b0;
      errOccOut <= '0;
    end else if (strb.clear) begin
      occ       <= '0;
      wrIdx     <= '0;
      rdIdx     <= '0;
      passB     <= 1'b0;
      thr       <= THR_A;
      errFlag   <= 1'b0;
      errOccOut <= '0;
    end else begin
      if (strb.doWrite) begin
        occ   <= occ + CNT_W'(1);
        wrIdx <= wrIdx + CNT_W'(1);
      end
      if (strb.doRead)  occ   <= occ - CNT_W'(1);
      if (strb.chkData) rdIdx <= rdIdx + CNT_W'(1);
      if (strb.nextPass) begin
        passB <= 1'b1;
        thr   <= THR_B;
        wrIdx <= '0;
        rdIdx <= '0;
      end
      if (mismatch && !errFlag) begin
        errFlag   <= 1'b1;
        errOccOut <= occ;
      end
    end
  end

  assign thrOut   = thr;
  assign isFull   = (occ == CNT_W'(DEPTH));
  assign isEmpty  = (occ == '0);
  assign lastPass = passB;

endmodule

// File: rtl/fifo_flag_bist.sv
module fifo_flag_bist
  import fifoflag_pkg::*;
#(
  parameter  int DEPTH = 8192,
  parameter  int WIDTH = 4,
  parameter  int THR_W = 13,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic             fwftMode,
  output logic             fifoWrEn,
  output logic [WIDTH-1:0] fifoWrData,
  output logic             fifoRdEn,
  input  logic [WIDTH-1:0] fifoRdData,
  input  logic             fifoFull,
  input  logic             fifoEmpty,
  input  logic             fifoAlmostFull,
  input  logic             fifoAlmostEmpty,
  output logic [THR_W-1:0] almostThresh,
  output logic             done,
  output logic             error,
  output logic [CNT_W-1:0] errOcc
);

  seqStrobe_t strb;
  logic       isFull, isEmpty, lastPass;

  ffseq_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .fwftMode (fwftMode),
    .isFull   (isFull),
    .isEmpty  (isEmpty),
    .lastPass (lastPass),
    .strb     (strb),
    .done     (done)
  );

  ffseq_datapath #(.DEPTH(DEPTH), .WIDTH(WIDTH), .THR_W(THR_W)) u_dp (
    .clk           (clk),
    .rstN          (rstN),
    .strb          (strb),
    .rdData        (fifoRdData),
    .fullIn        (fifoFull),
    .emptyIn       (fifoEmpty),
    .almostFullIn  (fifoAlmostFull),
    .almostEmptyIn (fifoAlmostEmpty),
    .wrData        (fifoWrData),
    .thrOut        (almostThresh),
    .isFull        (isFull),
    .isEmpty       (isEmpty),
    .lastPass      (lastPass),
    .errFlag       (error),
    .errOccOut     (errOcc)
  );

  assign fifoWrEn = strb.doWrite;
  assign fifoRdEn = strb.doRead;

endmodule

// File: rtl/ffseq_checker.sv
module ffseq_checker #(
  parameter int THR_W = 13,
  parameter int CNT_W = 14
) (
  input logic             clk,
  input logic             rstN,
  input logic             start,
  input logic             fifoWrEn,
  input logic             fifoRdEn,
  input logic [THR_W-1:0] almostThresh,
  input logic             done,
  input logic             error,
  input logic [CNT_W-1:0] errOcc
);

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(fifoWrEn && fifoRdEn)); // R4
  AST_WR_GAP: assert property (@(posedge clk) disable iff (!rstN)
    fifoWrEn |=> !fifoWrEn && !fifoRdEn); // R4
  AST_RD_GAP: assert property (@(posedge clk) disable iff (!rstN)
    fifoRdEn |=> !fifoRdEn && !fifoWrEn); // R4
  AST_THR_STEADY: assert property (@(posedge clk) disable iff (!rstN)
    fifoWrEn |=> $stable(almostThresh)); // R3
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    error && !start |=> error); // R10
  AST_ERROCC_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    error && !start |=> $stable(errOcc)); // R10
  AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    done && !start |=> done); // R11
  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !fifoWrEn && !fifoRdEn); // R11

endmodule

bind fifo_flag_bist ffseq_checker #(.THR_W(THR_W), .CNT_W(CNT_W)) u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .start        (start),
  .fifoWrEn     (fifoWrEn),
  .fifoRdEn     (fifoRdEn),
  .almostThresh (almostThresh),
  .done         (done),
  .error        (error),
  .errOcc       (errOcc)
);

// File: tb/sim_fifo_flag_bist.sv
`timescale 1ns/1ps
module sim_fifo_flag_bist;
  localparam int D  = 64;
  localparam int W  = 9;
  localparam int TW = 6;
  localparam int CW = $clog2(D + 1);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic fwft = 1'b0;
  logic wrEn, rdEn, full, empty, aFull, aEmpty, done, error;
  logic [W-1:0] wrData, rdData;
  logic [TW-1:0] thrOut;
  logic [CW-1:0] errOcc;

  always #5 clk = ~clk;

  fifo_flag_bist #(.DEPTH(D), .WIDTH(W), .THR_W(TW)) u0 (
    .clk(clk), .rstN(rstN), .start(start), .fwftMode(fwft),
    .fifoWrEn(wrEn), .fifoWrData(wrData), .fifoRdEn(rdEn), .fifoRdData(rdData),
    .fifoFull(full), .fifoEmpty(empty), .fifoAlmostFull(aFull), .fifoAlmostEmpty(aEmpty),
    .almostThresh(thrOut), .done(done), .error(error), .errOcc(errOcc)
  );

  // behavioural FIFO under test, with fault injection
  logic [W-1:0] mem [D];
  logic [W-1:0] rdReg;
  int wp, rp, occ, nWr;
  int fFlag = 0, fOcc = 0, dFault = 0, dIdx = 0;

  initial for (int i = 0; i < D; i++) mem[i] = '0;

  always @(posedge clk) begin
    if (!rstN) begin
      wp <= 0; rp <= 0; occ <= 0; nWr <= 0; rdReg <= '0;
    end else begin
      if (wrEn && occ < D) begin
        mem[wp] <= wrData ^ ((dFault != 0 && nWr == dIdx) ? W'(1) : W'(0));
        wp <= (wp + 1) % D;
        nWr <= nWr + 1;
      end
      if (rdEn && occ > 0) begin
        rdReg <= mem[rp];
        rp <= (rp + 1) % D;
      end
      occ <= occ + ((wrEn && occ < D) ? 1 : 0) - ((rdEn && occ > 0) ? 1 : 0);
    end
  end

  assign full   = (occ == D) ^ (fFlag == 1 && occ == fOcc);
  assign empty  = (occ == 0) ^ (fFlag == 2 && occ == fOcc);
  assign aFull  = (occ + int'(thrOut) >= D) ^ (fFlag == 3 && occ == fOcc);
  assign aEmpty = (occ <= int'(thrOut)) ^ (fFlag == 4 && occ == fOcc);
  assign rdData = fwft ? mem[rp] : rdReg;

  function automatic logic [W-1:0] expWord(int k, int p);
    logic [W-1:0] pat;
    for (int i = 0; i < W; i++) pat[i] = (p == 0) ? ((i % 2) == 1) : ((i % 2) == 0);
    return W'(k) ^ pat;
  endfunction

  function automatic logic [TW-1:0] expThr(int p);
    logic [TW-1:0] t;
    for (int i = 0; i < TW; i++) t[i] = (p == 0) ? ((i % 2) == 1) : ((i % 2) == 0);
    return t;
  endfunction

  // monitor of the strobes at the falling edge
  int monWr, monRd, wrBad, wrFull, both;
  logic [TW-1:0] thrSeen [2];
  always @(negedge clk) begin
    if (rstN) begin
      if (wrEn) begin
        if (monWr / D < 2) begin
          if (wrData != expWord(monWr % D, monWr / D)) wrBad++;
          if (monWr % D == 0) thrSeen[monWr / D] = thrOut;
        end
        if (occ >= D) wrFull++;
        monWr++;
      end
      if (rdEn) monRd++;
      if (wrEn && rdEn) both++;
    end
  end

  int checks = 0, errors = 0;
  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic runOnce(input bit doReset, input bit mode, input int flagSel,
                         input int flagOcc, input int dataFlt, input int dataIdx,
                         input int midStart);
    int cyc;
    bit expErr;
    int expOcc;
    if (doReset) begin
      @(negedge clk); rstN = 1'b0;
      repeat (3) @(negedge clk);
      rstN = 1'b1;
    end
    @(negedge clk);
    fwft = mode; fFlag = flagSel; fOcc = flagOcc; dFault = dataFlt; dIdx = dataIdx;
    monWr = 0; monRd = 0; wrBad = 0; wrFull = 0; both = 0;
    thrSeen[0] = '0; thrSeen[1] = '0;
    start = 1'b1;
    @(negedge clk); start = 1'b0; cyc = 1;
    while (!done && cyc < 20000) begin
      @(negedge clk); cyc++;
      start = (cyc == midStart);
    end
    start = 1'b0;
    chk(cyc < 20000, "R11", "watchdog", cyc, 8 * D + 3);
    chk(cyc == 8 * D + 3, "R11", "cycles to done", cyc, 8 * D + 3);
    chk(monWr == 2 * D, "R4", "write count", monWr, 2 * D);
    chk(monRd == 2 * D, "R4", "read count", monRd, 2 * D);
    chk(wrFull == 0 && both == 0, "R4", "write when full / overlap", wrFull + both, 0);
    chk(wrBad == 0, "R5", "write data order", wrBad, 0);
    chk(thrSeen[0] == expThr(0), "R3", "pass 1 threshold", thrSeen[0], expThr(0));
    chk(thrSeen[1] == expThr(1), "R3", "pass 2 threshold", thrSeen[1], expThr(1));
    expErr = (flagSel != 0) || (dataFlt != 0);
    expOcc = 0;
    if (flagSel != 0) expOcc = flagOcc;
    else if (dataFlt != 0) expOcc = mode ? D - dataIdx : D - dataIdx - 1;
    chk(error == expErr, flagSel != 0 ? (flagSel > 2 ? "R7" : "R6")
                         : (dataFlt != 0 ? (mode ? "R9" : "R8") : "R10"),
        "error", error, expErr);
    if (expErr) chk(int'(errOcc) == expOcc, "R10", "errOcc", errOcc, expOcc);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      if (!done || wrEn || rdEn) begin
        chk(1'b0, "R11", "done held and quiet", {done, wrEn, rdEn}, 3'b100);
      end
    end
  endtask

  initial begin
    int r;
    r = $urandom(32'h00C0FFEE);
    repeat (2) @(negedge clk);
    chk(!done && !error && !wrEn && !rdEn, "R1", "reset outputs",
        {done, error, wrEn, rdEn}, 0);
    chk(errOcc == '0 && thrOut == '0, "R1", "reset errOcc/thr", errOcc, 0);
    runOnce(1, 0, 0, 0, 0, 0, 150);        // R2 mid-run start ignored, standard clean
    runOnce(1, 1, 0, 0, 0, 0, 300);        // R9 fall-through clean
    runOnce(1, 0, 1, D, 0, 0, 0);          // R6 full wrong at DEPTH
    runOnce(1, 1, 2, 0, 0, 0, 0);          // R6 empty wrong at zero
    runOnce(1, 0, 3, 20, 0, 0, 0);         // R7 almost-full
    runOnce(1, 1, 4, 50, 0, 0, 0);         // R7 almost-empty
    runOnce(1, 0, 0, 0, 1, 0, 0);          // R8 first word corrupted
    runOnce(1, 1, 0, 0, 1, D - 1, 0);      // R9 last word corrupted
    runOnce(0, 0, 0, 0, 0, 0, 0);          // R10 restart from done clears error
    for (int n = 0; n < 4; n++) begin
      int fs, fo, md;
      md = $urandom % 2;
      fs = 1 + ($urandom % 4);
      fo = $urandom % (D + 1);
      runOnce(1, md[0], fs, fo, 0, 0, 0);
    end
    for (int n = 0; n < 2; n++) begin
      int md, k;
      md = $urandom % 2;
      k = $urandom % D;
      runOnce(1, md[0], 0, 0, 1, k, 0);
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #5000000;
    checks++; errors++;
    $display("FAIL global watchdog actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule